// File: doc/BRIEF.md
# Data flash access controller

This block sits between a CPU bus and a small byte-wide on-chip memory array that stands in for data flash. A one-bit enable in a control register gates all use of the array. CPU byte reads are answered after a fixed number of wait states. A separate rewrite port takes byte-program and block-erase commands, and each one occupies the array for a set number of cycles. While a rewrite runs, the `busy` output stays high.

The block enforces the lockouts that apply during a rewrite. Control-register writes are dropped, and sleep requests are refused and flagged. A CPU read that arrives during a rewrite is held off with ready low. When the code-memory self-programming input is high, every data access is refused. An instruction-fetch access to the data area is also refused. Programming follows flash rules: it can only clear bits, so the stored byte becomes the old byte ANDed with the new one. An erased byte reads 0xFF.

Top module: `dfc_top`

## Requirements
- R1: After reset `regRdData` is 0x00 and `busy` is low. Bit 0 of the control register is the enable. Bits 7:1 always read as zero, even after 0xFF is written.
- R2: The CPU holds `rdReq` and `rdAddr` until `rdReady`. For an accepted read, `rdReady` rises in the fourth cycle, counting the request cycle as the first. `rdData` then carries the stored byte and `rdErr` is low.
- R3: With the enable at 0, a read gets `rdReady` and `rdErr` high in the cycle after the request. A command gets a one-cycle `cmdErr` in the next cycle and `busy` stays low.
- R4: A program command (`cmdOp`=0) is accepted with `cmdErr` low. It raises `busy` for exactly PROG_CYCLES (default 8) cycles, starting the next cycle. The stored byte then becomes old AND `cmdData`.
- R5: An erase command (`cmdOp`=1) raises `busy` for exactly ERASE_CYCLES (default 64) cycles. It then sets every byte of the 1 KB block selected by address bits above bit 9 to 0xFF. The other block is left unchanged.
- R6: A control-register write made while `busy` is high has no effect.
- R7: While `busy` is high, `sleepReq` gives `sleepDeny` high and `sleepGrant` low. While idle it gives `sleepGrant` high.
- R8: While `selfProg` is high, reads get an error response as in R3 and commands get `cmdErr` with no `busy`.
- R9: A read with `rdFetch` high gets `rdReady` and `rdErr` in the next cycle.
- R10: A read requested while `busy` is high keeps `rdReady` low until `busy` has dropped. It then returns the byte as it stands after the rewrite.
- R11: A command issued while `busy` is high gets `cmdErr`. It does not change the operation in progress or the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register contents |
| rdReq | input | 1 | CPU byte read request, held until ready |
| rdFetch | input | 1 | Marks the read as an instruction fetch |
| rdAddr | input | ADDR_W | CPU read byte address |
| rdData | output | 8 | Read data, valid with ready and no error |
| rdReady | output | 1 | Read response strobe |
| rdErr | output | 1 | Read refused |
| cmdValid | input | 1 | Rewrite command strobe (one cycle) |
| cmdOp | input | 1 | 0 = program byte, 1 = erase block |
| cmdAddr | input | ADDR_W | Command byte address |
| cmdData | input | 8 | Program data |
| cmdErr | output | 1 | Command refused (one cycle) |
| busy | output | 1 | Rewrite in progress |
| selfProg | input | 1 | Code memory self-programming active |
| sleepReq | input | 1 | Halt/stop entry request |
| sleepGrant | output | 1 | Sleep entry allowed |
| sleepDeny | output | 1 | Sleep entry refused due to rewrite |

## Verification
Directed sequences cover the refusal paths: the enable off, self-programming on, instruction fetch, and a command during busy. Each path must give a one-cycle error and no rewrite. A refusal that comes from the wrong cause shows up as a missing error or a busy pulse. Repeated programs to the same byte show whether the array merges data by AND or overwrites it. An erase of one block after writes to both shows whether the erase is confined to its block. Random programs and reads over a narrow address set in both blocks are compared against a bench model of the array. That comparison separates correct AND-merge and addressing from aliasing between the blocks. A read issued mid-rewrite, a register write and a sleep request during busy exercise the lockouts.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic regWrite;     // commit control register write
    logic rdLatch;      // capture read address
    logic rdDrive;      // present array byte on rdData
    logic cmdLatch;     // capture command address and data
    logic progCommit;   // apply byte program
    logic eraseCommit;  // apply block erase
  } dfcStrobe_t;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_WAIT,
    RS_ERR
  } rdState_e;

  localparam logic OP_PROG  = 1'b0;
  localparam logic OP_ERASE = 1'b1;

endpackage

// File: rtl/dfc_control.sv
module dfc_control
  import dfc_pkg::*;
#(
  parameter int RD_WAIT      = 3,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       rdFetch,
  input  logic       selfProg,
  input  logic       cmdValid,
  input  logic       cmdOp,
  input  logic       regWrEn,
  input  logic       sleepReq,
  input  logic       enable,
  output dfcStrobe_t strb,
  output logic       rdReady,
  output logic       rdErr,
  output logic       cmdErr,
  output logic       busy,
  output logic       sleepGrant,
  output logic       sleepDeny
);

  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int RW_W    = $clog2(MAX_CYC + 1);
  localparam int RC_W    = $clog2(RD_WAIT + 1);

  rdState_e        rdState;
  logic [RC_W-1:0] rdCnt;
  logic            busyQ;
  logic            opQ;
  logic [RW_W-1:0] rwCnt;

  logic rdRefuse, rdGo, cmdRefuse, cmdAcc, rwDone;

  always_comb begin
    rdRefuse  = !enable || selfProg || rdFetch;
    rdGo      = (rdState == RS_IDLE) && rdReq && !rdRefuse && !busyQ;
    rdReady   = ((rdState == RS_WAIT) && (rdCnt == RC_W'(RD_WAIT - 1))) || (rdState == RS_ERR);
    rdErr     = (rdState == RS_ERR);
    cmdRefuse = !enable || selfProg || busyQ;
    cmdAcc    = cmdValid && !cmdRefuse;
    rwDone    = busyQ && (rwCnt == '0);

    strb.regWrite    = regWrEn && !busyQ;
    strb.rdLatch     = rdGo;
    strb.rdDrive     = rdReady && !rdErr;
    strb.cmdLatch    = cmdAcc;
    strb.progCommit  = rwDone && (opQ == OP_PROG);
    strb.eraseCommit = rwDone && (opQ == OP_ERASE);

    busy       = busyQ;
    sleepGrant = sleepReq && !busyQ;
    sleepDeny  = sleepReq && busyQ;
  end

  // Read wait-state sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdState <= RS_IDLE;
      rdCnt   <= '0;
    end else begin
      case (rdState)
        RS_IDLE: begin
          if (rdReq && rdRefuse) begin
            rdState <= RS_ERR;
          end else if (rdGo) begin
            rdState <= RS_WAIT;
            rdCnt   <= '0;
          end
        end
        RS_WAIT: begin
          if (rdCnt == RC_W'(RD_WAIT - 1)) rdState <= RS_IDLE;
          else                             rdCnt   <= rdCnt + 1'b1;
        end
        default: rdState <= RS_IDLE;
      endcase
    end
  end

  // Program / erase timing engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      opQ    <= OP_PROG;
      rwCnt  <= '0;
      cmdErr <= 1'b0;
    end else begin
      cmdErr <= cmdValid && cmdRefuse;
      if (cmdAcc) begin
        busyQ <= 1'b1;
        opQ   <= cmdOp;
        rwCnt <= (cmdOp == OP_ERASE) ? RW_W'(ERASE_CYCLES - 1) : RW_W'(PROG_CYCLES - 1);
      end else if (busyQ) begin
        if (rwCnt == '0) busyQ <= 1'b0;
        else             rwCnt <= rwCnt - 1'b1;
      end
    end
  end

  // Depth 2 holds for any RD_WAIT of 3 or more
  AST_READ_WAITED: assert property (@(posedge clk) disable iff (!rstN)
    rdReady && !rdErr |-> $past(rdReq) && $past(rdReq, 2)); // R2
  AST_CMD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !enable |=> cmdErr && !busy); // R3
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && rwCnt != '0 |=> busyQ); // R4
  AST_SLEEP_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    cmdAcc |=> !sleepGrant); // R7
  AST_SELFPROG_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdState == RS_IDLE && rdReq && selfProg |=> rdReady && rdErr); // R8
  AST_FETCH_ERR: assert property (@(posedge clk) disable iff (!rstN)
    rdState == RS_IDLE && rdReq && rdFetch |=> rdErr); // R9
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLatch |-> !busy); // R10
  AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && busyQ |=> cmdErr); // R11

endmodule

// File: rtl/dfc_datapath.sv
module dfc_datapath
  import dfc_pkg::*;
#(
  parameter int BLOCK_BYTES = 1024,
  parameter int NUM_BLOCKS  = 2,
  parameter int ADDR_W      = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dfcStrobe_t        strb,
  input  logic [7:0]        regWrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  output logic              enable,
  output logic [7:0]        regRdData,
  output logic [7:0]        rdData
);

  localparam int DEPTH = BLOCK_BYTES * NUM_BLOCKS;
  localparam int OFF_W = $clog2(BLOCK_BYTES);

  logic [7:0]        ctrlQ;
  logic [ADDR_W-1:0] rdAddrQ;
  logic [ADDR_W-1:0] cmdAddrQ;
  logic [7:0]        cmdDataQ;
  logic [7:0]        memArr [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= 8'h00;
      rdAddrQ  <= '0;
      cmdAddrQ <= '0;
      cmdDataQ <= 8'h00;
    end else begin
      if (strb.regWrite) ctrlQ   <= regWrData & 8'h01;
      if (strb.rdLatch)  rdAddrQ <= rdAddr;
      if (strb.cmdLatch) begin
        cmdAddrQ <= cmdAddr;
        cmdDataQ <= cmdData;
      end
    end
  end

  // Array contents survive reset, as flash does
  always_ff @(posedge clk) begin
    if (strb.progCommit) begin
      memArr[cmdAddrQ] <= memArr[cmdAddrQ] & cmdDataQ;
    end
    if (strb.eraseCommit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((i / BLOCK_BYTES) == int'(cmdAddrQ[ADDR_W-1:OFF_W])) memArr[i] <= 8'hFF;
      end
    end
  end

  always_comb begin
    enable    = ctrlQ[0];
    regRdData = ctrlQ;
    rdData    = strb.rdDrive ? memArr[rdAddrQ] : 8'h00;
  end

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    strb.progCommit |=> (memArr[cmdAddrQ] & ~$past(memArr[cmdAddrQ])) == 8'h00); // R4
  AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseCommit |=> memArr[cmdAddrQ] == 8'hFF
      && memArr[{cmdAddrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}] == 8'hFF); // R5

endmodule

// File: rtl/dfc_top.sv
module dfc_top
  import dfc_pkg::*;
#(
  parameter int BLOCK_BYTES  = 1024,
  parameter int NUM_BLOCKS   = 2,
  parameter int RD_WAIT      = 3,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 64,
  localparam int ADDR_W      = $clog2(BLOCK_BYTES * NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              rdReq,
  input  logic              rdFetch,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              rdReady,
  output logic              rdErr,
  input  logic              cmdValid,
  input  logic              cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  output logic              cmdErr,
  output logic              busy,
  input  logic              selfProg,
  input  logic              sleepReq,
  output logic              sleepGrant,
  output logic              sleepDeny
);

  dfcStrobe_t strb;
  logic       enable;

  dfc_control #(
    .RD_WAIT     (RD_WAIT),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdReq     (rdReq),
    .rdFetch   (rdFetch),
    .selfProg  (selfProg),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .regWrEn   (regWrEn),
    .sleepReq  (sleepReq),
    .enable    (enable),
    .strb      (strb),
    .rdReady   (rdReady),
    .rdErr     (rdErr),
    .cmdErr    (cmdErr),
    .busy      (busy),
    .sleepGrant(sleepGrant),
    .sleepDeny (sleepDeny)
  );

  dfc_datapath #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .NUM_BLOCKS (NUM_BLOCKS),
    .ADDR_W     (ADDR_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regWrData(regWrData),
    .rdAddr   (rdAddr),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .enable   (enable),
    .regRdData(regRdData),
    .rdData   (rdData)
  );

  AST_REG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    busy && regWrEn |=> regRdData == $past(regRdData)); // R6

endmodule

// File: tb/sim_dfc_top.sv
`timescale 1ns/1ps
module sim_dfc_top;

  localparam int BLOCK_BYTES = 1024;
  localparam int NUM_BLOCKS  = 2;
  localparam int DEPTH       = BLOCK_BYTES * NUM_BLOCKS;
  localparam int AW          = 11;
  localparam int PROG_CYC    = 8;
  localparam int ERASE_CYC   = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regWrData = 8'h00;
  logic [7:0]    regRdData;
  logic          rdReq = 1'b0;
  logic          rdFetch = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    rdData;
  logic          rdReady, rdErr;
  logic          cmdValid = 1'b0;
  logic          cmdOp = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [7:0]    cmdData = 8'h00;
  logic          cmdErr, busy;
  logic          selfProg = 1'b0;
  logic          sleepReq = 1'b0;
  logic          sleepGrant, sleepDeny;

  dfc_top #(
    .BLOCK_BYTES(BLOCK_BYTES), .NUM_BLOCKS(NUM_BLOCKS), .RD_WAIT(3),
    .PROG_CYCLES(PROG_CYC), .ERASE_CYCLES(ERASE_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .rdReq(rdReq), .rdFetch(rdFetch), .rdAddr(rdAddr), .rdData(rdData), .rdReady(rdReady),
    .rdErr(rdErr), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .cmdErr(cmdErr), .busy(busy), .selfProg(selfProg), .sleepReq(sleepReq),
    .sleepGrant(sleepGrant), .sleepDeny(sleepDeny)
  );

  always #4 clk = ~clk;

  int         errors = 0;
  int         checks = 0;
  bit         ended = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] d;
  bit         e;
  int         n;

  function automatic logic [7:0] progExpect(logic [7:0] oldV, logic [7:0] newV);
    return oldV & newV;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doRead(input logic [AW-1:0] a, input bit fetch,
                        output logic [7:0] dOut, output bit eOut, output int nOut);
    rdReq = 1'b1; rdAddr = a; rdFetch = fetch; nOut = 0;
    tick(); nOut++;
    while (!rdReady && nOut < 500) begin tick(); nOut++; end
    dOut = rdData; eOut = rdErr;
    rdReq = 1'b0; rdFetch = 1'b0;
    tick();
  endtask

  task automatic doCmd(input bit op, input logic [AW-1:0] a, input logic [7:0] dat,
                       output bit eOut, output int nOut);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = dat;
    tick();
    cmdValid = 1'b0;
    eOut = cmdErr; nOut = 0;
    while (busy && nOut < 1000) begin nOut++; tick(); end
  endtask

  task automatic modelErase(input logic [AW-1:0] a);
    for (int i = 0; i < DEPTH; i++)
      if (i / BLOCK_BYTES == int'(a) / BLOCK_BYTES) model[i] = 8'hFF;
  endtask

  initial begin
    #1200000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk(regRdData == 8'h00, "R1 reset register", regRdData, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);

    // Disabled: read and command refused
    doRead(11'd5, 0, d, e, n);
    chk(e && n == 1, "R3 read while disabled", {e, 8'(n)}, 9'h101);
    doCmd(1'b0, 11'd5, 8'h00, e, n);
    chk(e && n == 0, "R3 command while disabled", {e, 8'(n)}, 9'h100);

    regWrEn = 1'b1; regWrData = 8'hFF; tick(); regWrEn = 1'b0;
    chk(regRdData == 8'h01, "R1 upper bits zero", regRdData, 8'h01);

    doCmd(1'b1, 11'd3, 8'h00, e, n);
    chk(!e && n == ERASE_CYC, "R5 erase busy span", n, ERASE_CYC);
    doCmd(1'b1, 11'(BLOCK_BYTES + 7), 8'h00, e, n);
    modelErase(11'd0); modelErase(11'(BLOCK_BYTES));

    doRead(11'd0, 0, d, e, n);
    chk(!e && n == 4 - 1 + 0 && d == 8'hFF, "R2 read timing erased", {d, 8'(n)}, 16'hFF03);
    doRead(11'(DEPTH - 1), 0, d, e, n);
    chk(!e && d == 8'hFF, "R5 erased top byte", d, 8'hFF);

    doCmd(1'b0, 11'd10, 8'h5A, e, n);
    chk(!e && n == PROG_CYC, "R4 program busy span", n, PROG_CYC);
    model[10] = progExpect(model[10], 8'h5A);
    doRead(11'd10, 0, d, e, n);
    chk(d == 8'h5A && n == 3, "R2 R4 read after program", d, 8'h5A);
    doCmd(1'b0, 11'd10, 8'h0F, e, n);
    model[10] = progExpect(model[10], 8'h0F);
    doRead(11'd10, 0, d, e, n);
    chk(d == 8'h0A, "R4 program ANDs", d, 8'h0A);

    // Random programs and reads over a narrow address set
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      a = AW'(($urandom % NUM_BLOCKS) * BLOCK_BYTES + ($urandom % 16));
      if ($urandom % 2 == 0) begin
        logic [7:0] v;
        v = 8'($urandom);
        doCmd(1'b0, a, v, e, n);
        model[a] = progExpect(model[a], v);
        chk(!e && n == PROG_CYC, "R4 random program", n, PROG_CYC);
      end else begin
        doRead(a, 0, d, e, n);
        chk(!e && n == 3 && d == model[a], "R2 random read", d, model[a]);
      end
    end

    // Erase one block, other untouched
    doCmd(1'b0, 11'(BLOCK_BYTES + 30), 8'h33, e, n);
    model[BLOCK_BYTES + 30] = progExpect(model[BLOCK_BYTES + 30], 8'h33);
    doCmd(1'b1, 11'd500, 8'h00, e, n);
    modelErase(11'd500);
    doRead(11'd10, 0, d, e, n);
    chk(d == 8'hFF, "R5 erased block byte", d, 8'hFF);
    doRead(11'(BLOCK_BYTES + 30), 0, d, e, n);
    chk(d == model[BLOCK_BYTES + 30], "R5 other block kept", d, model[BLOCK_BYTES + 30]);

    doRead(11'd3, 1, d, e, n);
    chk(e && n == 1, "R9 fetch refused", {e, 8'(n)}, 9'h101);

    selfProg = 1'b1;
    doRead(11'd3, 0, d, e, n);
    chk(e && n == 1, "R8 read during self-program", {e, 8'(n)}, 9'h101);
    doCmd(1'b0, 11'd3, 8'h00, e, n);
    chk(e && n == 0, "R8 command during self-program", {e, 8'(n)}, 9'h100);
    selfProg = 1'b0;
    doRead(11'd3, 0, d, e, n);
    chk(!e && d == 8'hFF, "R8 command had no effect", d, 8'hFF);

    // Lockouts during a rewrite
    cmdValid = 1'b1; cmdOp = 1'b0; cmdAddr = 11'd20; cmdData = 8'h00;
    tick(); cmdValid = 1'b0;
    model[20] = 8'h00;
    sleepReq = 1'b1;
    #1;
    chk(sleepDeny && !sleepGrant, "R7 sleep refused when busy", {sleepDeny, sleepGrant}, 2'b10);
    sleepReq = 1'b0;
    regWrEn = 1'b1; regWrData = 8'h00; tick(); regWrEn = 1'b0;
    chk(regRdData == 8'h01, "R6 register write ignored", regRdData, 8'h01);
    cmdValid = 1'b1; cmdOp = 1'b1; cmdAddr = 11'(BLOCK_BYTES); tick(); cmdValid = 1'b0;
    chk(cmdErr == 1'b1, "R11 command while busy refused", cmdErr, 1);
    begin
      bit early;
      early = 0;
      rdReq = 1'b1; rdAddr = 11'd20; n = 0;
      tick(); n++;
      while (!rdReady && n < 500) begin
        tick(); n++;
      end
      if (busy) early = 1;
      d = rdData;
      rdReq = 1'b0;
      chk(!early && n > 3, "R10 read held off", n, 4);
      chk(d == 8'h00, "R10 read sees new value", d, 0);
      tick();
    end
    doRead(11'(BLOCK_BYTES + 30), 0, d, e, n);
    chk(d == model[BLOCK_BYTES + 30], "R11 refused erase no effect", d, model[BLOCK_BYTES + 30]);
    sleepReq = 1'b1;
    #1;
    chk(sleepGrant && !sleepDeny, "R7 sleep granted idle", {sleepDeny, sleepGrant}, 2'b01);
    sleepReq = 1'b0;
    tick();

    finishRun();
  end

endmodule